// File: doc/BRIEF.md
# CAN Acceptance Mask Filter

This block decides, for one received CAN frame, which receive message buffers and which receive-FIFO filter-table elements would accept it. Each buffer and each FIFO element supplies a programmed 32-bit filter word and an enable bit. The block holds its own mask registers and ANDs the difference between the filter word and the received frame with the mask that applies to that entry. An entry matches when no checked bit differs. Picking a winner among several hits, and storing the frame, are left to the logic that follows.

Two mask schemes are available. In the shared scheme one global mask serves most entries, and two dedicated masks serve the last two buffers and the last two FIFO elements. In the per-entry scheme every buffer and every element has its own mask, and the shared masks are ignored. A second configuration bit turns FIFO mode on. Mask registers can be written only while the freeze flag is high. The match vectors are combinational and valid in the same cycle as the received-frame strobe.

Frame word layout, for filters and for the received frame: bit 31 is RTR, bit 30 is IDE, bit 29 is unused, and bits 28:0 hold the 29-bit extended identifier. A standard 11-bit identifier sits in bits 28:18.

Top module: `can_accept_filter`

## Requirements
- R1: A mask bit of 1 requires the filter bit to equal the received bit. A mask bit of 0 makes that filter bit a don't-care.
- R2: In the shared scheme (`cfg_indiv_en_i`=0), buffers 0..13 use the global mask. Buffer 14 uses dedicated mask A and buffer 15 uses dedicated mask B.
- R3: In the shared scheme, FIFO elements 0..5 use the global mask. Element 6 uses dedicated mask A and element 7 uses dedicated mask B.
- R4: Buffer comparison covers only identifier bits 28:0. Element comparison also covers IDE (bit 30) and RTR (bit 31). Bit 29 never takes part in either comparison.
- R5: In the per-entry scheme (`cfg_indiv_en_i`=1), each buffer and each element uses its own mask. Changing the global or dedicated masks then has no effect on the match vectors.
- R6: After reset, every mask register holds 32'hFFFF_FFFF, so every covered bit is checked.
- R7: A write takes effect at the clock edge only when `wr_en_i` and `freeze_i` are both high; otherwise it is ignored. Address map: 0 is the global mask, 1 is dedicated mask A, 2 is dedicated mask B, 16+b is the mask of buffer b, and 32+e is the mask of element e. Writes to any other address are ignored.
- R8: A buffer or element whose enable bit is 0 never matches. No element matches while `cfg_fifo_en_i` is 0.
- R9: Both match vectors are all zero while `rx_valid_i` is 0. While it is 1, they reflect the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Freeze flag; mask writes are allowed only while it is high |
| cfg_indiv_en_i | input | 1 | 1 selects per-entry masks, 0 selects shared masks |
| cfg_fifo_en_i | input | 1 | Enables FIFO filter-element matching |
| wr_en_i | input | 1 | Mask register write strobe |
| wr_addr_i | input | 6 | Mask register address |
| wr_data_i | input | 32 | Mask write data |
| rx_valid_i | input | 1 | Received-frame strobe |
| rx_id_i | input | 29 | Received identifier (standard ID in bits 28:18) |
| rx_ide_i | input | 1 | Received IDE bit |
| rx_rtr_i | input | 1 | Received RTR bit |
| buf_enable_i | input | 16 | Per-buffer receive enable |
| buf_filter_i | input | 512 | Buffer filter words, buffer b in bits 32b+31:32b |
| elem_enable_i | input | 8 | Per-element enable |
| elem_filter_i | input | 256 | Element filter words, element e in bits 32e+31:32e |
| buf_match_o | output | 16 | Buffer match vector |
| elem_match_o | output | 8 | FIFO element match vector |

## Verification
The assertions check four things on every cycle:
- Both vectors stay quiet without a frame strobe.
- Disabled entries stay silent, and elements stay silent while FIFO mode is off.
- Masks hold their value across any cycle in which freeze is low.
- An exact identifier match always hits, and in the shared scheme element 6 and buffer 14 get the same mask.

Some behaviours only the bench's scenarios can show: which mask each entry picks in each scheme, the per-bit don't-care meaning of a mask, the all-ones reset value, and the extra IDE/RTR coverage of elements. The bench shows them by sweeping a single-bit mismatch across all 32 positions under distinct mask contents.

// File: rtl/can_accept_pkg.sv
package can_accept_pkg;
    localparam int WORD_W   = 32;
    localparam int ID_W     = 29;
    localparam int IDE_POS  = 30;
    localparam int RTR_POS  = 31;

    typedef logic [WORD_W-1:0] word_t;

    // bits compared for buffers: identifier only
    localparam word_t BUF_COVER  = word_t'({ID_W{1'b1}});
    // bits compared for FIFO elements: identifier, IDE and RTR
    localparam word_t ELEM_COVER = BUF_COVER | (word_t'(1) << IDE_POS) | (word_t'(1) << RTR_POS);

    localparam word_t MASK_RESET = '1;

    typedef enum logic {
        MASK_SHARED    = 1'b0,
        MASK_PER_ENTRY = 1'b1
    } mask_scheme_e;

    function automatic word_t pack_frame(input logic [ID_W-1:0] id,
                                         input logic ide,
                                         input logic rtr);
        word_t w;
        w = '0;
        w[ID_W-1:0] = id;
        w[IDE_POS]  = ide;
        w[RTR_POS]  = rtr;
        return w;
    endfunction
endpackage

// File: rtl/can_mask_regs.sv
module can_mask_regs
    import can_accept_pkg::*;
#(
    parameter int NUM_BUF   = 16,
    parameter int NUM_ELEM  = 8,
    parameter int BUF_BASE  = 16,
    parameter int ELEM_BASE = 32,
    parameter int ADDR_W    = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             freeze_i,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  word_t                            wr_data_i,
    output word_t                            glob_o,
    output word_t                            ded_a_o,
    output word_t                            ded_b_o,
    output logic [NUM_BUF-1:0][WORD_W-1:0]   ind_buf_o,
    output logic [NUM_ELEM-1:0][WORD_W-1:0]  ind_elem_o
);
    localparam logic [ADDR_W-1:0] ADR_GLOB  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_DED_A = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_DED_B = ADDR_W'(2);

    logic wr_ok;
    assign wr_ok = wr_en_i & freeze_i;

    word_t glob_q, ded_a_q, ded_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q  <= MASK_RESET;
            ded_a_q <= MASK_RESET;
            ded_b_q <= MASK_RESET;
        end else if (wr_ok) begin
            if (wr_addr_i == ADR_GLOB)  glob_q  <= wr_data_i;
            if (wr_addr_i == ADR_DED_A) ded_a_q <= wr_data_i;
            if (wr_addr_i == ADR_DED_B) ded_b_q <= wr_data_i;
        end
    end

    assign glob_o  = glob_q;
    assign ded_a_o = ded_a_q;
    assign ded_b_o = ded_b_q;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf_mask
        localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(BUF_BASE + b);
        word_t m_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               m_q <= MASK_RESET;
            else if (wr_ok && wr_addr_i == MY_ADR)    m_q <= wr_data_i;
        end
        assign ind_buf_o[b] = m_q;
    end

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem_mask
        localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(ELEM_BASE + e);
        word_t m_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               m_q <= MASK_RESET;
            else if (wr_ok && wr_addr_i == MY_ADR)    m_q <= wr_data_i;
        end
        assign ind_elem_o[e] = m_q;
    end

    AST_NO_WRITE_OUTSIDE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_i |=> ($stable(glob_o) && $stable(ded_a_o) && $stable(ded_b_o))); // R7
    AST_NO_WRITE_IND_OUTSIDE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_i |=> ($stable(ind_buf_o) && $stable(ind_elem_o))); // R7
endmodule

// File: rtl/can_mask_select.sv
module can_mask_select
    import can_accept_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  mask_scheme_e                     scheme_i,
    input  word_t                            glob_i,
    input  word_t                            ded_a_i,
    input  word_t                            ded_b_i,
    input  logic [NUM_ENT-1:0][WORD_W-1:0]   ind_i,
    output logic [NUM_ENT-1:0][WORD_W-1:0]   mask_o
);
    localparam int IDX_A = NUM_ENT - 2;
    localparam int IDX_B = NUM_ENT - 1;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_sel
        word_t shared_m;
        if (i == IDX_A) begin : g_ded_a
            assign shared_m = ded_a_i;
        end else if (i == IDX_B) begin : g_ded_b
            assign shared_m = ded_b_i;
        end else begin : g_glob
            assign shared_m = glob_i;
        end

        always_comb begin
            unique case (scheme_i)
                MASK_SHARED:    mask_o[i] = shared_m;
                MASK_PER_ENTRY: mask_o[i] = ind_i[i];
                default:        mask_o[i] = ind_i[i];
            endcase
        end
    end
endmodule

// File: rtl/can_accept_cmp.sv
module can_accept_cmp
    import can_accept_pkg::*;
#(
    parameter int    NUM_ENT = 16,
    parameter word_t COVER   = BUF_COVER
) (
    input  word_t                            rx_word_i,
    input  logic                             gate_i,
    input  logic [NUM_ENT-1:0]               enable_i,
    input  logic [NUM_ENT-1:0][WORD_W-1:0]   filter_i,
    input  logic [NUM_ENT-1:0][WORD_W-1:0]   mask_i,
    output logic [NUM_ENT-1:0]               hit_o
);
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        word_t diff;
        assign diff     = (filter_i[i] ^ rx_word_i) & mask_i[i] & COVER;
        assign hit_o[i] = gate_i & enable_i[i] & ~|diff;
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_accept_pkg::*;
#(
    parameter int NUM_BUF  = 16,
    parameter int NUM_ELEM = 8,
    parameter int BUF_BASE = 16,
    parameter int ELEM_BASE = BUF_BASE + NUM_BUF,
    parameter int ADDR_W   = $clog2(ELEM_BASE + NUM_ELEM)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         freeze_i,
    input  logic                         cfg_indiv_en_i,
    input  logic                         cfg_fifo_en_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [31:0]                  wr_data_i,
    input  logic                         rx_valid_i,
    input  logic [28:0]                  rx_id_i,
    input  logic                         rx_ide_i,
    input  logic                         rx_rtr_i,
    input  logic [NUM_BUF-1:0]           buf_enable_i,
    input  logic [NUM_BUF*32-1:0]        buf_filter_i,
    input  logic [NUM_ELEM-1:0]          elem_enable_i,
    input  logic [NUM_ELEM*32-1:0]       elem_filter_i,
    output logic [NUM_BUF-1:0]           buf_match_o,
    output logic [NUM_ELEM-1:0]          elem_match_o
);
    mask_scheme_e scheme;
    assign scheme = cfg_indiv_en_i ? MASK_PER_ENTRY : MASK_SHARED;

    word_t glob_m, ded_a_m, ded_b_m, rx_word;
    logic [NUM_BUF-1:0][WORD_W-1:0]  ind_buf_m, buf_mask, buf_filt;
    logic [NUM_ELEM-1:0][WORD_W-1:0] ind_elem_m, elem_mask, elem_filt;

    assign rx_word   = pack_frame(rx_id_i, rx_ide_i, rx_rtr_i);
    assign buf_filt  = buf_filter_i;
    assign elem_filt = elem_filter_i;

    can_mask_regs #(
        .NUM_BUF(NUM_BUF), .NUM_ELEM(NUM_ELEM),
        .BUF_BASE(BUF_BASE), .ELEM_BASE(ELEM_BASE), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .glob_o(glob_m), .ded_a_o(ded_a_m), .ded_b_o(ded_b_m),
        .ind_buf_o(ind_buf_m), .ind_elem_o(ind_elem_m)
    );

    can_mask_select #(.NUM_ENT(NUM_BUF)) u_sel_buf (
        .scheme_i(scheme), .glob_i(glob_m), .ded_a_i(ded_a_m), .ded_b_i(ded_b_m),
        .ind_i(ind_buf_m), .mask_o(buf_mask)
    );

    can_mask_select #(.NUM_ENT(NUM_ELEM)) u_sel_elem (
        .scheme_i(scheme), .glob_i(glob_m), .ded_a_i(ded_a_m), .ded_b_i(ded_b_m),
        .ind_i(ind_elem_m), .mask_o(elem_mask)
    );

    can_accept_cmp #(.NUM_ENT(NUM_BUF), .COVER(BUF_COVER)) u_cmp_buf (
        .rx_word_i(rx_word), .gate_i(rx_valid_i), .enable_i(buf_enable_i),
        .filter_i(buf_filt), .mask_i(buf_mask), .hit_o(buf_match_o)
    );

    can_accept_cmp #(.NUM_ENT(NUM_ELEM), .COVER(ELEM_COVER)) u_cmp_elem (
        .rx_word_i(rx_word), .gate_i(rx_valid_i & cfg_fifo_en_i), .enable_i(elem_enable_i),
        .filter_i(elem_filt), .mask_i(elem_mask), .hit_o(elem_match_o)
    );

    AST_NO_HIT_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_i |-> (buf_match_o == '0 && elem_match_o == '0)); // R9
    AST_FIFO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en_i |-> (elem_match_o == '0)); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_match_o & ~buf_enable_i) == '0) && ((elem_match_o & ~elem_enable_i) == '0)); // R8
    AST_EXACT_ID_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && buf_enable_i[0] && buf_filter_i[28:0] == rx_id_i) |-> buf_match_o[0]); // R1
    AST_SHARED_DEDICATED_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme == MASK_SHARED) |->
        (elem_mask[NUM_ELEM-2] == buf_mask[NUM_BUF-2] && elem_mask[NUM_ELEM-1] == buf_mask[NUM_BUF-1])); // R3
endmodule

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
    localparam int NB = 16;
    localparam int NE = 8;
    localparam logic [31:0] BCOV = 32'h1FFF_FFFF;
    localparam logic [31:0] ECOV = 32'hDFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freeze = 1'b0, indiv = 1'b0, fifo = 1'b0;
    logic wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic rx_ide = 1'b0, rx_rtr = 1'b0;
    logic [NB-1:0] ben = '0;
    logic [NE-1:0] een = '0;
    logic [31:0] bf [NB];
    logic [31:0] ef [NE];
    logic [NB*32-1:0] bf_flat;
    logic [NE*32-1:0] ef_flat;
    logic [NB-1:0] bmatch;
    logic [NE-1:0] ematch;

    logic [31:0] sh_g, sh_a, sh_b;
    logic [31:0] sh_ib [NB];
    logic [31:0] sh_ie [NE];

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) bf_flat[i*32 +: 32] = bf[i];
        for (int i = 0; i < NE; i++) ef_flat[i*32 +: 32] = ef[i];
    end

    can_accept_filter u_can_accept_filter (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze), .cfg_indiv_en_i(indiv),
        .cfg_fifo_en_i(fifo), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rx_valid_i(rx_valid), .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr),
        .buf_enable_i(ben), .buf_filter_i(bf_flat), .elem_enable_i(een),
        .elem_filter_i(ef_flat), .buf_match_o(bmatch), .elem_match_o(ematch)
    );

    function automatic logic [31:0] bmask(int b);
        if (indiv) return sh_ib[b];
        if (b == NB-2) return sh_a;
        if (b == NB-1) return sh_b;
        return sh_g;
    endfunction

    function automatic logic [31:0] emask(int e);
        if (indiv) return sh_ie[e];
        if (e == NE-2) return sh_a;
        if (e == NE-1) return sh_b;
        return sh_g;
    endfunction

    function automatic logic [31:0] rxw();
        return {rx_rtr, rx_ide, 1'b0, rx_id};
    endfunction

    task automatic check_all(input string req);
        logic [NB-1:0] eb;
        logic [NE-1:0] ee;
        for (int b = 0; b < NB; b++)
            eb[b] = rx_valid && ben[b] && (((bf[b] ^ rxw()) & bmask(b) & BCOV) == 0);
        for (int e = 0; e < NE; e++)
            ee[e] = rx_valid && fifo && een[e] && (((ef[e] ^ rxw()) & emask(e) & ECOV) == 0);
        n_checks++;
        if (bmatch !== eb) begin
            n_fail++;
            $display("FAIL %s buffers actual %h expected %h", req, bmatch, eb);
        end
        n_checks++;
        if (ematch !== ee) begin
            n_fail++;
            $display("FAIL %s elements actual %h expected %h", req, ematch, ee);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (freeze) begin
            if (a == 0) sh_g = d;
            else if (a == 1) sh_a = d;
            else if (a == 2) sh_b = d;
            else if (a >= 16 && a < 32) sh_ib[a-16] = d;
            else if (a >= 32 && a < 40) sh_ie[a-32] = d;
        end
    endtask

    // every filter differs from the frame in bit k only
    task automatic sweep(input string req);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            for (int b = 0; b < NB; b++) bf[b] = rxw() ^ (32'h1 << k);
            for (int e = 0; e < NE; e++) ef[e] = rxw() ^ (32'h1 << k);
            #1 check_all(req);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        sh_g = '1; sh_a = '1; sh_b = '1;
        for (int i = 0; i < NB; i++) begin sh_ib[i] = '1; bf[i] = '0; end
        for (int i = 0; i < NE; i++) begin sh_ie[i] = '1; ef[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset masks all ones, every covered bit checked; R4 bit 29 ignored
        ben = '1; een = '1; fifo = 1'b1; rx_valid = 1'b1;
        rx_id = 29'h0ABC_1234; rx_ide = 1'b1; rx_rtr = 1'b0;
        sweep("R6_R4");

        // R9: no frame strobe, no hits
        @(negedge clk); rx_valid = 1'b0;
        for (int b = 0; b < NB; b++) bf[b] = rxw();
        for (int e = 0; e < NE; e++) ef[e] = rxw();
        #1 check_all("R9");
        n_checks++;
        if (bmatch !== '0) begin n_fail++; $display("FAIL R9 actual %h expected 0", bmatch); end
        @(negedge clk); rx_valid = 1'b1;
        #1 check_all("R9");

        // R7: writes outside freeze are ignored
        wr(6'd0, 32'h0); wr(6'd1, 32'h0); wr(6'd16, 32'h0); wr(6'd39, 32'h0);
        sweep("R7");

        // R2, R3, R1: distinct shared masks under freeze
        freeze = 1'b1;
        wr(6'd0, 32'hFFFF_FF00);
        wr(6'd1, 32'hFFFF_00FF);
        wr(6'd2, 32'h00FF_FFFF);
        wr(6'd5, 32'h0);       // unmapped, ignored (R7)
        freeze = 1'b0;
        sweep("R2_R3_R1");
        rx_ide = 1'b0; rx_rtr = 1'b1; rx_id = {11'h5A3, 18'h0};
        sweep("R4");

        // R5: per-entry masks, each clearing a distinct bit
        freeze = 1'b1;
        for (int b = 0; b < NB; b++) wr(6'(16 + b), ~(32'h1 << b));
        for (int e = 0; e < NE; e++) wr(6'(32 + e), ~(32'h1 << (e + 16)));
        indiv = 1'b1;
        sweep("R5");
        wr(6'd0, 32'h0); wr(6'd1, 32'h0); wr(6'd2, 32'h0);
        freeze = 1'b0;
        sweep("R5");

        // R8: random enables, FIFO on and off
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            ben = 16'($urandom); een = 8'($urandom); fifo = n[0];
            indiv = n[1];
            rx_id = 29'($urandom); rx_ide = n[2]; rx_rtr = n[3];
            for (int b = 0; b < NB; b++) bf[b] = ($urandom % 3 == 0) ? rxw() ^ (32'h1 << ($urandom % 32)) : rxw();
            for (int e = 0; e < NE; e++) ef[e] = ($urandom % 3 == 0) ? rxw() ^ (32'h1 << ($urandom % 32)) : rxw();
            #1 check_all("R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule